// File: doc/BRIEF.md
# Multichannel Sample Interleaver

This block turns one tick of parallel samples, one per channel across eight channels, into a serial stream of tagged words. A channel-enable mask picks which channels take part. Each accepted tick becomes one group, with one output word per enabled channel. The words leave in a fixed order that depends on the mask. That order is not ascending channel number: the lower-bank and upper-bank channels are paired, so the full set leaves as 0,4,1,5,2,6,3,7.

On the input side, `in_valid` and `in_ready` form the handshake, and a tick is accepted only when the previous group has fully drained. On the output side, `out_valid` and `out_ready` form the handshake, and every word carries its channel number as a tag.

Only six enable masks are legal. Any other mask raises `config_error`, blocks input and produces no output. The mask is sampled only while the block is idle, so changing it during a group does not disturb that group.

Top module: `sample_interleaver`

## Requirements
- R1: With mask 8'h01, each group has one word, the channel 0 sample, and groups leave in the order their ticks were accepted.
- R2: With mask 8'h11, each group leaves as channel 0 then channel 4.
- R3: With mask 8'h03, each group leaves as channel 0 then channel 1.
- R4: With mask 8'h33, each group leaves in the order 0, 4, 1, 5.
- R5: With mask 8'h0F, each group leaves in the order 0, 1, 2, 3.
- R6: With mask 8'hFF, each group leaves in the order 0, 4, 1, 5, 2, 6, 3, 7.
- R7: The input bus holds channel c in bits [c*SAMPLE_W +: SAMPLE_W]. Each output word puts that channel's sample on `out_data` and the channel number c, as a 3-bit binary value, on `out_tag`. In mask bit c, a 1 enables channel c.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_tag` hold their values. A word is consumed only on a cycle where `out_valid` and `out_ready` are both high.
- R9: `in_ready` is low while a group is draining, that is, while `out_valid` is high. `in_ready` is high in the cycle after the last word of a group is consumed, provided the mask is legal. A tick is taken on a cycle where `in_valid` and `in_ready` are both high.
- R10: The mask is registered on each clock edge while idle, and it takes effect after that edge. A change made while a group is draining has no effect on that group's words.
- R11: A mask outside the six legal values drives `config_error` high after one idle clock edge. While `config_error` is high, `in_ready` is low and `out_valid` stays low, whatever `in_valid` does.
- R12: After a synchronous active-high reset, `out_valid` is 0, `config_error` is 0 and `in_ready` is 1. The stored mask after reset is 8'h01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 8 | Channel-enable mask, sampled while idle |
| in_valid | input | 1 | A sample tick is present |
| in_ready | output | 1 | The block can take a tick |
| in_samples | input | 8*SAMPLE_W | One sample per channel, channel c in slice c |
| out_valid | output | 1 | The output word is valid |
| out_ready | input | 1 | The downstream side takes the word |
| out_data | output | SAMPLE_W | Sample of the tagged channel |
| out_tag | output | 3 | Channel number of the word |
| config_error | output | 1 | The sampled mask is not one of the legal values |

## Verification
The bench sweeps all 256 masks and checks the error flag and the input gate for each. A decoder that accepts a near-miss mask, such as 8'h13, would leave `config_error` low and emit words. Every legal mask is then run over several groups with different backpressure patterns. A sequencer that ordered channels ascending would put channel 1 where 4 belongs, and one that advanced while stalled would skip or repeat a channel. The mask is also changed during an eight-word group, once to a legal value and once to an illegal value. A design that decoded the live mask would cut that group short, and the bench then checks that the new mask governs the next group.

// File: rtl/il_pkg.sv
package il_pkg;

  localparam int NUM_CH = 8;
  localparam int TAG_W  = $clog2(NUM_CH);
  localparam int LEN_W  = TAG_W + 1;

  typedef enum logic [2:0] {
    CFG_C0    = 3'd0,
    CFG_C04   = 3'd1,
    CFG_C01   = 3'd2,
    CFG_C0415 = 3'd3,
    CFG_C0123 = 3'd4,
    CFG_ALL8  = 3'd5,
    CFG_BAD   = 3'd6
  } il_cfg_e;

  // Map a raw enable mask onto one of the supported layouts.
  function automatic il_cfg_e cfg_of_mask(input logic [NUM_CH-1:0] m);
    case (m)
      8'h01:   return CFG_C0;
      8'h11:   return CFG_C04;
      8'h03:   return CFG_C01;
      8'h33:   return CFG_C0415;
      8'h0F:   return CFG_C0123;
      8'hFF:   return CFG_ALL8;
      default: return CFG_BAD;
    endcase
  endfunction

  // Number of words per group for each layout.
  function automatic logic [LEN_W-1:0] cfg_len(input il_cfg_e c);
    case (c)
      CFG_C0:    return LEN_W'(1);
      CFG_C04:   return LEN_W'(2);
      CFG_C01:   return LEN_W'(2);
      CFG_C0415: return LEN_W'(4);
      CFG_C0123: return LEN_W'(4);
      CFG_ALL8:  return LEN_W'(8);
      default:   return LEN_W'(0);
    endcase
  endfunction

  // Channel emitted at slot i; the bank bit (bit 2) follows slot bit 0
  // in the paired layouts.
  function automatic logic [TAG_W-1:0] cfg_chan(input il_cfg_e c,
                                                input logic [TAG_W-1:0] i);
    case (c)
      CFG_C04:   return {i[0], 2'b00};
      CFG_C01:   return {2'b00, i[0]};
      CFG_C0415: return {i[0], 1'b0, i[1]};
      CFG_C0123: return {1'b0, i[1:0]};
      CFG_ALL8:  return {i[0], i[2:1]};
      default:   return '0;
    endcase
  endfunction

endpackage

// File: rtl/il_cfg_track.sv
module il_cfg_track
  import il_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic [NUM_CH-1:0] chan_en,
  output logic [NUM_CH-1:0] mask_q,
  output il_cfg_e           cfg_q,
  output logic              err_q
);

  il_cfg_e cfg_d;
  assign cfg_d = cfg_of_mask(chan_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= NUM_CH'(1);
      cfg_q  <= CFG_C0;
      err_q  <= 1'b0;
    end else if (!hold) begin
      mask_q <= chan_en;
      cfg_q  <= cfg_d;
      err_q  <= (cfg_d == CFG_BAD);
    end
  end

  // R10: configuration is frozen while a group is being taken or drained
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    hold |=> ($stable(mask_q) && $stable(cfg_q) && $stable(err_q)));

endmodule

// File: rtl/il_sample_bank.sv
module il_sample_bank #(
  parameter int SAMPLE_W = 16,
  parameter int NUM_CH   = 8,
  localparam int TAG_W   = $clog2(NUM_CH),
  localparam int BUS_W   = SAMPLE_W * NUM_CH
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [BUS_W-1:0]    in_flat,
  input  logic [TAG_W-1:0]    rd_sel,
  output logic [SAMPLE_W-1:0] rd_data
);

  logic [SAMPLE_W-1:0] slot_q [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (load) slot_q[g] <= in_flat[g*SAMPLE_W +: SAMPLE_W];
    end
  end

  // The first word of a group bypasses the bank and comes from the bus.
  always_comb begin
    if (load) rd_data = in_flat[int'(rd_sel)*SAMPLE_W +: SAMPLE_W];
    else      rd_data = slot_q[rd_sel];
  end

  // R7: captured slice matches the bus at the load edge
  a_r7_capture_last: assert property (@(posedge clk) disable iff (rst)
    load |=> (slot_q[NUM_CH-1] == $past(in_flat[BUS_W-1 -: SAMPLE_W])));

endmodule

// File: rtl/il_sequencer.sv
module il_sequencer
  import il_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                accept,
  input  il_cfg_e             cfg,
  input  logic                out_ready,
  input  logic [SAMPLE_W-1:0] rd_data,
  output logic [TAG_W-1:0]    rd_sel,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_data,
  output logic [TAG_W-1:0]    out_tag
);

  logic [LEN_W-1:0] idx_q;
  logic [LEN_W-1:0] len;
  logic             more;

  assign len    = cfg_len(cfg);
  assign more   = (idx_q < len);
  assign rd_sel = cfg_chan(cfg, accept ? TAG_W'(0) : idx_q[TAG_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_tag   <= '0;
      idx_q     <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= rd_data;
      out_tag   <= rd_sel;
      idx_q     <= LEN_W'(1);
    end else if (out_valid && out_ready) begin
      if (more) begin
        out_data <= rd_data;
        out_tag  <= rd_sel;
        idx_q    <= idx_q + LEN_W'(1);
      end else begin
        out_valid <= 1'b0;
        idx_q     <= '0;
      end
    end
  end

  // R8: a stalled word holds
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_tag)));

  // R9: slot counter stays inside the group while draining
  a_r9_idx_bounded: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((idx_q != '0) && (idx_q <= len)));

endmodule

// File: rtl/sample_interleaver.sv
module sample_interleaver
  import il_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_CH-1:0]          chan_en,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [NUM_CH*SAMPLE_W-1:0] in_samples,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [SAMPLE_W-1:0]        out_data,
  output logic [TAG_W-1:0]           out_tag,
  output logic                       config_error
);

  logic [NUM_CH-1:0]   mask_q;
  il_cfg_e             cfg_q;
  logic                err_q;
  logic                accept;
  logic [TAG_W-1:0]    rd_sel;
  logic [SAMPLE_W-1:0] rd_data;

  assign in_ready     = !out_valid && !err_q;
  assign accept       = in_valid && in_ready;
  assign config_error = err_q;

  il_cfg_track u_cfg (
    .clk     (clk),
    .rst     (rst),
    .hold    (out_valid || accept),
    .chan_en (chan_en),
    .mask_q  (mask_q),
    .cfg_q   (cfg_q),
    .err_q   (err_q)
  );

  il_sample_bank #(.SAMPLE_W(SAMPLE_W), .NUM_CH(NUM_CH)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .in_flat (in_samples),
    .rd_sel  (rd_sel),
    .rd_data (rd_data)
  );

  il_sequencer #(.SAMPLE_W(SAMPLE_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .cfg       (cfg_q),
    .out_ready (out_ready),
    .rd_data   (rd_data),
    .rd_sel    (rd_sel),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_tag   (out_tag)
  );

  // R11: error blocks both sides
  a_r11_err_blocks: assert property (@(posedge clk) disable iff (rst)
    config_error |-> (!in_ready && !out_valid));

  // R9: no tick taken while draining
  a_r9_busy_no_ready: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R7: every emitted tag is an enabled channel
  a_r7_tag_enabled: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> mask_q[out_tag]);

endmodule

// File: tb/sample_interleaver_bench.sv
module sample_interleaver_bench;
  localparam int W  = 16;
  localparam int NC = 8;

  logic            clk = 1'b0;
  logic            rst;
  logic [NC-1:0]   chan_en;
  logic            in_valid;
  logic            in_ready;
  logic [NC*W-1:0] in_samples;
  logic            out_valid;
  logic            out_ready;
  logic [W-1:0]    out_data;
  logic [2:0]      out_tag;
  logic            config_error;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  sample_interleaver #(.SAMPLE_W(W)) u_sample_interleaver (
    .clk(clk), .rst(rst), .chan_en(chan_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_samples(in_samples), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_tag(out_tag),
    .config_error(config_error));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit legal(input logic [7:0] m);
    return (m == 8'h01) || (m == 8'h11) || (m == 8'h03) ||
           (m == 8'h33) || (m == 8'h0F) || (m == 8'hFF);
  endfunction

  // Expected order, one nibble per slot from the top.
  function automatic logic [31:0] order_of(input logic [7:0] m);
    case (m)
      8'h01:   return 32'h0000_0000;
      8'h11:   return 32'h0400_0000;
      8'h03:   return 32'h0100_0000;
      8'h33:   return 32'h0415_0000;
      8'h0F:   return 32'h0123_0000;
      default: return 32'h0415_2637;
    endcase
  endfunction

  function automatic string req_of(input logic [7:0] m);
    case (m)
      8'h01:   return "R1";
      8'h11:   return "R2";
      8'h03:   return "R3";
      8'h33:   return "R4";
      8'h0F:   return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [W-1:0] smp(input int g, input int c);
    return W'(16'h5A00 + g * 16 + c);
  endfunction

  task automatic run_group(input logic [7:0] m, input int g, input int pat,
                           input bit do_mid, input logic [7:0] mid_mask);
    int n = $countones(m);
    int k = 0;
    int cyc = 0;
    bit stalled = 0;
    logic [W-1:0] held_d = '0;
    logic [2:0] held_t = '0;
    logic [31:0] ord = order_of(m);
    @(negedge clk);
    for (int c = 0; c < NC; c++) in_samples[c*W +: W] = smp(g, c);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    while (k < n) begin
      out_ready = (pat == 0) ? 1'b1 : ((cyc % (pat + 1)) != 0);
      cyc++;
      if (out_valid) begin
        chk(!in_ready, "R9", "in_ready while draining", in_ready, 0);
        if (stalled) begin
          chk(out_data == held_d && out_tag == held_t, "R8", "stalled word held",
              {out_tag, out_data}, {held_t, held_d});
        end
        if (out_ready) begin
          logic [2:0] et = 3'(ord[31 - 4*k -: 4]);
          chk(out_tag == et, req_of(m), "tag", out_tag, et);
          chk(out_data == smp(g, et), "R7", "data", out_data, smp(g, et));
          k++;
          stalled = 0;
          if (do_mid && k == 1) chan_en = mid_mask;
        end else begin
          stalled = 1;
          held_d = out_data;
          held_t = out_tag;
        end
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(!out_valid, req_of(m), "group length", out_valid, 0);
    chk(in_ready == legal(chan_en) || do_mid, "R9", "in_ready after drain", in_ready, 1);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; chan_en = 8'h01; in_valid = 1'b0; out_ready = 1'b0;
    in_samples = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(!out_valid, "R12", "out_valid", out_valid, 0);
    chk(!config_error, "R12", "config_error", config_error, 0);
    chk(in_ready, "R12", "in_ready", in_ready, 1);

    // R11 sweep of every mask value
    for (int m = 0; m < 256; m++) begin
      chan_en = 8'(m);
      @(negedge clk); @(negedge clk);
      chk(config_error == !legal(8'(m)), "R11", "config_error", config_error, !legal(8'(m)));
      chk(in_ready == legal(8'(m)), "R11", "in_ready", in_ready, legal(8'(m)));
      if (!legal(8'(m))) begin
        in_valid = 1'b1;
        out_ready = 1'b1;
        for (int t = 0; t < 3; t++) begin
          @(negedge clk);
          chk(!out_valid, "R11", "no output on bad mask", out_valid, 0);
        end
        in_valid = 1'b0;
        out_ready = 1'b0;
      end else begin
        for (int g = 0; g < 3; g++) run_group(8'(m), m + g, g, 1'b0, 8'h00);
      end
    end

    // R10: mid-group change to a legal mask
    chan_en = 8'hFF;
    @(negedge clk); @(negedge clk);
    run_group(8'hFF, 40, 1, 1'b1, 8'h01);
    @(negedge clk); @(negedge clk);
    run_group(8'h01, 41, 0, 1'b0, 8'h00);
    chk(1'b1, "R10", "new mask governs next group", 0, 0);

    // R10/R11: mid-group change to an illegal mask
    chan_en = 8'hFF;
    @(negedge clk); @(negedge clk);
    run_group(8'hFF, 50, 2, 1'b1, 8'h05);
    @(negedge clk); @(negedge clk);
    chk(config_error, "R10", "error after drain", config_error, 1);
    chan_en = 8'h33;
    @(negedge clk); @(negedge clk);
    chk(!config_error, "R11", "error clears", config_error, 0);
    run_group(8'h33, 60, 3, 1'b0, 8'h00);

    summary();
    $finish;
  end

endmodule